// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block performs the control-register side of taking an exception in a small processor. Each cycle it receives a set of exception request lines, the address of the instruction being interrupted, and two configured vector addresses. When a request is accepted, it updates the status word, saves the prior status into the exception-status or break-status register, records a 5-bit cause code, stores the return address (interrupted PC plus 4) into the exception-return or break-return register, and issues a program-counter redirect. All of these updates take effect on the same clock edge.

The saving rules depend on whether the exception-handling bit was already set. A nested exception must not overwrite the context of the first one. A TLB miss is handled in one of two ways. A first-level miss goes to a dedicated fast vector and arms the TLB write-enable flag. A miss taken inside a handler is a double miss: it sets the double-miss flag and goes to the general vector. The surrounding core can also write the status word directly, for example to enable interrupts or leave handler mode.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, the status, exception-status, break-status, cause, exception-return and break-return registers are all zero. The double-miss and write-enable flags are zero, and `redir_vld` is low.
- R2: Request lines are bit 0 interrupt, bit 1 TLB miss, bit 2 read-permission, bit 3 write-permission, bit 4 execute-permission, bit 5 supervisor-only violation, bit 6 trap, bit 7 illegal instruction, bit 8 break. When several lines are high, the highest-numbered one is taken, so an interrupt has the lowest priority. Exactly one request is acted on per cycle.
- R3: Status bits are bit 0 interrupt-enable, bit 1 user mode, bit 2 exception-handling and bit 3 interrupt-handling. A taken exception clears interrupt-enable and user mode. It sets interrupt-handling if the exception is an interrupt, and exception-handling otherwise. It writes the parameterised cause code of the exception. In the next cycle `redir_vld` is high with `redir_pc` equal to the vector.
- R4: An interrupt is accepted only while interrupt-enable is 1. A masked interrupt request changes no register. An accepted interrupt copies status to exception-status, stores PC+4 in exception-return, and redirects to the general vector.
- R5: A TLB miss taken while exception-handling is 0 does the following: copies status to exception-status, clears the double-miss flag, sets the write-enable flag, stores PC+4 in exception-return, and redirects to the fast-miss vector.
- R6: A TLB miss taken while exception-handling is 1 sets the double-miss flag. It leaves exception-status, exception-return and the write-enable flag unchanged, and redirects to the general vector.
- R7: A permission exception (read, write or execute) always copies status to exception-status and PC+4 to exception-return, then redirects to the general vector.
- R8: A supervisor-only violation, trap or illegal instruction saves status and PC+4 only when exception-handling was 0. It always redirects to the general vector.
- R9: A break saves status into break-status and PC+4 into break-return only when exception-handling was 0. It leaves exception-status and exception-return unchanged and redirects to the general vector.
- R10: A status write loads `stat_wr_data` into status when no exception is taken that cycle. A taken exception overrides a status write in the same cycle.
- R11: In a cycle with no taken exception, `redir_vld` is low on the next cycle. The saved-context registers, cause and TLB flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 9 | Exception request lines, bit map in R2 |
| cur_pc | input | 32 | Address of the interrupted instruction |
| vec_general | input | 32 | General exception vector |
| vec_fastmiss | input | 32 | Fast TLB-miss vector |
| stat_wr_en | input | 1 | Direct status write strobe |
| stat_wr_data | input | 4 | Value for a direct status write |
| redir_vld | output | 1 | PC redirect issued (one cycle) |
| redir_pc | output | 32 | Redirect target |
| status | output | 4 | Status word, bit map in R3 |
| estatus | output | 4 | Exception-status register |
| bstatus | output | 4 | Break-status register |
| cause | output | 5 | Cause code of the last taken exception |
| exc_ret | output | 32 | Exception-return address |
| brk_ret | output | 32 | Break-return address |
| tlb_dbl | output | 1 | Double-miss flag |
| tlb_we | output | 1 | TLB write-enable flag |

## Verification
Every result is a register. The effect of inputs applied before a rising edge can be seen on all outputs right after that edge, and the redirect lasts exactly that one cycle. The bench drives inputs after a falling edge and waits for the next rising edge. It compares at 2 ns past that edge against a model, which it advances once per cycle from the same inputs. It therefore never reads a value that is one cycle early or late. Directed sequences cover masked interrupts, fast and double misses, nested breaks, and a status write that collides with an exception. Seeded random traffic mixes single and multiple requests with random status writes.

// File: rtl/exc_pkg.sv
// Package: shared request indices and status bit positions for the
// exception entry sequencer. Assumes a 9-line request vector.
package exc_pkg;
    localparam int NUM_EXC  = 9;
    localparam int CAUSE_W  = 5;
    localparam int STAT_W   = 4;

    // Request line positions; a higher index has higher priority.
    localparam int X_IRQ    = 0;
    localparam int X_MISS   = 1;
    localparam int X_PRD    = 2;
    localparam int X_PWR    = 3;
    localparam int X_PEX    = 4;
    localparam int X_SUPV   = 5;
    localparam int X_TRAP   = 6;
    localparam int X_ILL    = 7;
    localparam int X_BRK    = 8;

    // Status bit positions.
    localparam int S_PIE    = 0;
    localparam int S_USR    = 1;
    localparam int S_EH     = 2;
    localparam int S_IH     = 3;
endpackage

// File: rtl/exc_arbiter.sv
// Module: fixed-priority arbiter. Masks the interrupt line when interrupts
// are disabled, then grants the highest-indexed active request.
// Assumes line 0 is the interrupt and carries the lowest priority.
module exc_arbiter #(
    parameter int N = 9
) (
    input  logic [N-1:0] req,
    input  logic         irq_enable,
    output logic [N-1:0] grant,
    output logic         any
);
    logic [N-1:0] req_eff;
    logic [N:0]   above;

    // Purpose: drop the interrupt request while it is masked.
    always_comb begin
        req_eff    = req;
        req_eff[0] = req[0] & irq_enable;
    end

    assign above[N] = 1'b0;
    for (genvar i = N - 1; i >= 0; i--) begin : g_chain
        assign above[i] = above[i+1] | req_eff[i];
        assign grant[i] = req_eff[i] & ~above[i+1];
    end
    assign any = above[0];
endmodule

// File: rtl/exc_update.sv
// Module: combinational next-state logic for the exception entry.
// Given a one-hot grant and the present register values, it computes
// every register's next value and the redirect target.
// Assumes grant has at most one bit set.
module exc_update
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [CAUSE_W-1:0] C_IRQ  = 5'd2,
    parameter logic [CAUSE_W-1:0] C_MISS = 5'd12,
    parameter logic [CAUSE_W-1:0] C_PRD  = 5'd13,
    parameter logic [CAUSE_W-1:0] C_PWR  = 5'd14,
    parameter logic [CAUSE_W-1:0] C_PEX  = 5'd15,
    parameter logic [CAUSE_W-1:0] C_SUPV = 5'd11,
    parameter logic [CAUSE_W-1:0] C_TRAP = 5'd3,
    parameter logic [CAUSE_W-1:0] C_ILL  = 5'd5,
    parameter logic [CAUSE_W-1:0] C_BRK  = 5'd7
) (
    input  logic [NUM_EXC-1:0] grant,
    input  logic               taken,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      vgen,
    input  logic [AW-1:0]      vfast,
    input  logic               wr_en,
    input  logic [STAT_W-1:0]  wr_data,
    input  logic [STAT_W-1:0]  st,
    input  logic [STAT_W-1:0]  est,
    input  logic [STAT_W-1:0]  bst,
    input  logic [CAUSE_W-1:0] cs,
    input  logic [AW-1:0]      ea,
    input  logic [AW-1:0]      ba,
    input  logic               dbl,
    input  logic               we,
    output logic [STAT_W-1:0]  n_st,
    output logic [STAT_W-1:0]  n_est,
    output logic [STAT_W-1:0]  n_bst,
    output logic [CAUSE_W-1:0] n_cs,
    output logic [AW-1:0]      n_ea,
    output logic [AW-1:0]      n_ba,
    output logic               n_dbl,
    output logic               n_we,
    output logic [AW-1:0]      n_pc
);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic [CAUSE_W-1:0] code_tbl [NUM_EXC];
    logic [AW-1:0]      pc_ret;
    logic               in_handler;
    logic               is_perm;
    logic               is_cond;

    assign code_tbl[X_IRQ]  = C_IRQ;
    assign code_tbl[X_MISS] = C_MISS;
    assign code_tbl[X_PRD]  = C_PRD;
    assign code_tbl[X_PWR]  = C_PWR;
    assign code_tbl[X_PEX]  = C_PEX;
    assign code_tbl[X_SUPV] = C_SUPV;
    assign code_tbl[X_TRAP] = C_TRAP;
    assign code_tbl[X_ILL]  = C_ILL;
    assign code_tbl[X_BRK]  = C_BRK;

    assign pc_ret     = pc + STEP;
    assign in_handler = st[S_EH];
    assign is_perm    = grant[X_PRD] | grant[X_PWR] | grant[X_PEX];
    assign is_cond    = grant[X_SUPV] | grant[X_TRAP] | grant[X_ILL];

    // Purpose: next status word, either exception entry or a direct write.
    always_comb begin
        n_st = st;
        if (taken) begin
            n_st[S_PIE] = 1'b0;
            n_st[S_USR] = 1'b0;
            if (grant[X_IRQ]) n_st[S_IH] = 1'b1;
            else              n_st[S_EH] = 1'b1;
        end else if (wr_en) begin
            n_st = wr_data;
        end
    end

    // Purpose: cause code of the granted exception.
    always_comb begin
        n_cs = cs;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (grant[i]) n_cs = code_tbl[i];
        end
    end

    // Purpose: saved context, TLB flags and redirect target per exception kind.
    always_comb begin
        n_est = est;
        n_bst = bst;
        n_ea  = ea;
        n_ba  = ba;
        n_dbl = dbl;
        n_we  = we;
        n_pc  = vgen;
        if (grant[X_IRQ] || is_perm) begin
            n_est = st;
            n_ea  = pc_ret;
        end
        if (grant[X_MISS]) begin
            if (!in_handler) begin
                n_est = st;
                n_ea  = pc_ret;
                n_dbl = 1'b0;
                n_we  = 1'b1;
                n_pc  = vfast;
            end else begin
                n_dbl = 1'b1;
            end
        end
        if (is_cond && !in_handler) begin
            n_est = st;
            n_ea  = pc_ret;
        end
        if (grant[X_BRK] && !in_handler) begin
            n_bst = st;
            n_ba  = pc_ret;
        end
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Module: exception entry sequencer top. Holds the status, saved-status,
// cause and return-address registers and the TLB miss flags. It updates them
// all on the edge where an exception is taken and issues a one-cycle
// redirect. Assumes request lines are sampled once per cycle; a request
// held high is taken again on every cycle.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [CAUSE_W-1:0] C_IRQ  = 5'd2,
    parameter logic [CAUSE_W-1:0] C_MISS = 5'd12,
    parameter logic [CAUSE_W-1:0] C_PRD  = 5'd13,
    parameter logic [CAUSE_W-1:0] C_PWR  = 5'd14,
    parameter logic [CAUSE_W-1:0] C_PEX  = 5'd15,
    parameter logic [CAUSE_W-1:0] C_SUPV = 5'd11,
    parameter logic [CAUSE_W-1:0] C_TRAP = 5'd3,
    parameter logic [CAUSE_W-1:0] C_ILL  = 5'd5,
    parameter logic [CAUSE_W-1:0] C_BRK  = 5'd7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [8:0]         exc_req,
    input  logic [AW-1:0]      cur_pc,
    input  logic [AW-1:0]      vec_general,
    input  logic [AW-1:0]      vec_fastmiss,
    input  logic               stat_wr_en,
    input  logic [3:0]         stat_wr_data,
    output logic               redir_vld,
    output logic [AW-1:0]      redir_pc,
    output logic [3:0]         status,
    output logic [3:0]         estatus,
    output logic [3:0]         bstatus,
    output logic [4:0]         cause,
    output logic [AW-1:0]      exc_ret,
    output logic [AW-1:0]      brk_ret,
    output logic               tlb_dbl,
    output logic               tlb_we
);
    logic [NUM_EXC-1:0] grant;
    logic               taken;
    logic [STAT_W-1:0]  n_st, n_est, n_bst;
    logic [CAUSE_W-1:0] n_cs;
    logic [AW-1:0]      n_ea, n_ba, n_pc;
    logic               n_dbl, n_we;

    exc_arbiter #(.N(NUM_EXC)) u_arb (
        .req        (exc_req),
        .irq_enable (status[S_PIE]),
        .grant      (grant),
        .any        (taken)
    );

    exc_update #(
        .AW(AW), .C_IRQ(C_IRQ), .C_MISS(C_MISS), .C_PRD(C_PRD),
        .C_PWR(C_PWR), .C_PEX(C_PEX), .C_SUPV(C_SUPV), .C_TRAP(C_TRAP),
        .C_ILL(C_ILL), .C_BRK(C_BRK)
    ) u_upd (
        .grant(grant), .taken(taken), .pc(cur_pc), .vgen(vec_general),
        .vfast(vec_fastmiss), .wr_en(stat_wr_en), .wr_data(stat_wr_data),
        .st(status), .est(estatus), .bst(bstatus), .cs(cause),
        .ea(exc_ret), .ba(brk_ret), .dbl(tlb_dbl), .we(tlb_we),
        .n_st(n_st), .n_est(n_est), .n_bst(n_bst), .n_cs(n_cs),
        .n_ea(n_ea), .n_ba(n_ba), .n_dbl(n_dbl), .n_we(n_we), .n_pc(n_pc)
    );

    // Purpose: commit every register update and the redirect on one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_vld <= 1'b0;
            redir_pc  <= '0;
            status    <= '0;
            estatus   <= '0;
            bstatus   <= '0;
            cause     <= '0;
            exc_ret   <= '0;
            brk_ret   <= '0;
            tlb_dbl   <= 1'b0;
            tlb_we    <= 1'b0;
        end else begin
            redir_vld <= taken;
            if (taken) redir_pc <= n_pc;
            status    <= n_st;
            estatus   <= n_est;
            bstatus   <= n_bst;
            cause     <= n_cs;
            exc_ret   <= n_ea;
            brk_ret   <= n_ba;
            tlb_dbl   <= n_dbl;
            tlb_we    <= n_we;
        end
    end

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_target_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (redir_vld && (redir_pc == $past(vec_general) ||
                                 redir_pc == $past(vec_fastmiss))));

    assert_mode_after_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (!status[S_PIE] && !status[S_USR] && (status[S_EH] || status[S_IH])));

    assert_masked_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req == 9'd1 && !status[S_PIE]) |=> (!redir_vld && $stable(exc_ret)));

    assert_fast_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[X_MISS] && !status[S_EH]) |=>
            (redir_pc == $past(vec_fastmiss) && tlb_we && !tlb_dbl));

    assert_double_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[X_MISS] && status[S_EH]) |=>
            ($stable(exc_ret) && $stable(estatus) && tlb_dbl));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> (!redir_vld && $stable(cause) && $stable(brk_ret)));
endmodule

// File: tb/tb_exc_entry_seq.sv
// Bench: model-based checks of the exception entry sequencer, with
// directed corner cases followed by seeded random traffic.
module tb_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  exc_req = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] vec_general = 32'h0000_0120;
    logic [31:0] vec_fastmiss = 32'h0000_0400;
    logic        stat_wr_en = 1'b0;
    logic [3:0]  stat_wr_data = '0;
    logic        redir_vld;
    logic [31:0] redir_pc, exc_ret, brk_ret;
    logic [3:0]  status, estatus, bstatus;
    logic [4:0]  cause;
    logic        tlb_dbl, tlb_we;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    logic [3:0]  m_st = '0, m_est = '0, m_bst = '0;
    logic [4:0]  m_cs = '0;
    logic [31:0] m_ea = '0, m_ba = '0, m_pc = '0;
    logic        m_vld = 0, m_dbl = 0, m_we = 0;

    exc_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .cur_pc(cur_pc),
        .vec_general(vec_general), .vec_fastmiss(vec_fastmiss),
        .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
        .redir_vld(redir_vld), .redir_pc(redir_pc), .status(status),
        .estatus(estatus), .bstatus(bstatus), .cause(cause),
        .exc_ret(exc_ret), .brk_ret(brk_ret), .tlb_dbl(tlb_dbl), .tlb_we(tlb_we)
    );

    always #4 clk = ~clk;

    function automatic logic [4:0] code_of(input int k);
        case (k)
            0: return 5'd2;  1: return 5'd12; 2: return 5'd13;
            3: return 5'd14; 4: return 5'd15; 5: return 5'd11;
            6: return 5'd3;  7: return 5'd5;  default: return 5'd7;
        endcase
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            -1: return "R11";
            0: return "R4";  1: return "R5/R6";
            2, 3, 4: return "R7";
            5, 6, 7: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Advance model by one cycle; returns granted index or -1.
    function automatic int model_step(input logic [8:0] r, input logic [31:0] p,
                                      input logic we, input logic [3:0] wd);
        logic [8:0] eff;
        int k;
        logic eh;
        eff = r;
        if (!m_st[0]) eff[0] = 1'b0;
        k = -1;
        for (int i = 0; i < 9; i++) if (eff[i]) k = i;
        eh = m_st[2];
        m_vld = (k >= 0);
        if (k < 0) begin
            if (we) m_st = wd;
            return k;
        end
        m_cs = code_of(k);
        m_pc = vec_general;
        case (k)
            0: begin m_est = m_st; m_ea = p + 4; end
            1: if (!eh) begin
                   m_est = m_st; m_ea = p + 4; m_dbl = 0; m_we = 1; m_pc = vec_fastmiss;
               end else m_dbl = 1;
            2, 3, 4: begin m_est = m_st; m_ea = p + 4; end
            5, 6, 7: if (!eh) begin m_est = m_st; m_ea = p + 4; end
            default: if (!eh) begin m_bst = m_st; m_ba = p + 4; end
        endcase
        m_st[0] = 0; m_st[1] = 0;
        if (k == 0) m_st[3] = 1; else m_st[2] = 1;
        return k;
    endfunction

    task automatic compare_all(input string tag);
        chk(tag, "redir_vld", 32'(redir_vld), 32'(m_vld));
        if (m_vld) chk(tag, "redir_pc", redir_pc, m_pc);
        chk(tag, "status", 32'(status), 32'(m_st));
        chk(tag, "estatus", 32'(estatus), 32'(m_est));
        chk(tag, "bstatus", 32'(bstatus), 32'(m_bst));
        chk(tag, "cause", 32'(cause), 32'(m_cs));
        chk(tag, "exc_ret", exc_ret, m_ea);
        chk(tag, "brk_ret", brk_ret, m_ba);
        chk(tag, "tlb_dbl", 32'(tlb_dbl), 32'(m_dbl));
        chk(tag, "tlb_we", 32'(tlb_we), 32'(m_we));
    endtask

    task automatic step(input logic [8:0] r, input logic [31:0] p,
                        input logic we, input logic [3:0] wd);
        int k;
        @(negedge clk);
        exc_req = r; cur_pc = p; stat_wr_en = we; stat_wr_data = wd;
        k = model_step(r, p, we, wd);
        @(posedge clk);
        #2;
        compare_all(tag_of(k));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; exc_req = '0; stat_wr_en = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_st = '0; m_est = '0; m_bst = '0; m_cs = '0; m_ea = '0; m_ba = '0;
        m_vld = 0; m_dbl = 0; m_we = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        do_reset();
        #1;
        compare_all("R1");
        chk("R1", "reset redir_vld", 32'(redir_vld), 32'd0);

        // R4: masked interrupt is ignored
        step(9'h001, 32'h1000, 0, 4'h0);
        chk("R4", "masked irq redir", 32'(redir_vld), 32'd0);
        // R10: status write enables interrupts, then irq taken
        step(9'h000, 32'h0, 1, 4'b0011);
        chk("R10", "status write", 32'(status), 32'h3);
        step(9'h001, 32'h2000, 0, 4'h0);
        chk("R4", "irq exc_ret", exc_ret, 32'h2004);
        chk("R3", "irq status", 32'(status), 32'b1000);
        // R5: fast miss with handler bit clear
        step(9'h002, 32'h3000, 0, 4'h0);
        chk("R5", "fast vector", redir_pc, 32'h400);
        // R6: now EH clear? IH only set; clear then force double miss
        step(9'h002, 32'h3100, 0, 4'h0);
        chk("R6", "double flag", 32'(tlb_dbl), 32'd1);
        chk("R6", "double keeps ret", exc_ret, 32'h3004);
        // R9: break while in handler saves nothing
        step(9'h100, 32'h3200, 0, 4'h0);
        chk("R9", "nested break ret", brk_ret, 32'h0);
        // R10: collision, exception wins
        step(9'h040, 32'h3300, 1, 4'b0001);
        chk("R10", "collision status", 32'(status), 32'(m_st));
        // R2: priority among several lines
        step(9'h0FF, 32'h3400, 0, 4'h0);
        chk("R2", "priority cause", 32'(cause), 32'd5);
        step(9'h000, 32'h0, 1, 4'b0001);
        step(9'h101, 32'h3500, 0, 4'h0);
        chk("R2", "break beats irq", 32'(cause), 32'd7);
        chk("R9", "break ret", brk_ret, 32'h3504);
        // R7: permission saves even inside handler
        step(9'h008, 32'h3600, 0, 4'h0);
        chk("R7", "perm ret", exc_ret, 32'h3604);
        // R8: trap inside handler keeps ret
        step(9'h040, 32'h3700, 0, 4'h0);
        chk("R8", "nested trap ret", exc_ret, 32'h3604);
        step(9'h000, 32'h0, 0, 4'h0);
        chk("R11", "idle redir", 32'(redir_vld), 32'd0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [8:0]  r;
            logic [31:0] p;
            int sel;
            sel = $urandom % 8;
            if (sel < 3)      r = '0;
            else if (sel < 7) r = 9'(1) << ($urandom % 9);
            else              r = 9'($urandom);
            p = {$urandom, 2'b00} >> 2 << 2;
            step(r, p, ($urandom % 3) == 0, 4'($urandom));
            if ((n % 500) == 499) do_reset();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule